// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives three inverter legs. Each leg has a high-side and a low-side gate output. All timing comes from one signed up/down counter. The counter ramps from `-HALF` to `+HALF` and back, so one switching period lasts `4*HALF` clock cycles and every pulse is symmetric about the counter's lower turn.

Each phase takes a signed duty command in two's complement, centred on zero. The high side conducts while the counter is below that command. A command at either end of the range pins the leg fully on or fully off, with no edges at all. Complementary outputs are separated by a programmable dead gap.

Period, dead gap and duty values are written into live configuration pins. They reach the active copies only at reload points: the start of each period, plus the upper turn when double-update mode is selected. An external sync pulse restarts the period at once. A per-output enable mask and a global polarity select shape the pins. A trip input forces every output to its inactive level without waiting for a clock edge, and the trip stays latched until it is cleared.

The block has no streaming data path. Every input is a level-sampled control pin.

Top module: `tri_pwm_core`

## Requirements
- R1: The counter runs `-HALF, -HALF+1, ..., +HALF, +HALF-1, ..., -HALF+1` and then starts again at `-HALF`, so a period is `4*HALF` cycles. Its value appears on `pwm_count`, and it never leaves `[-HALF_active, +HALF_active]`.
- R2: `period_start` is high in the cycle where the counter equals `-HALF_active` while counting up. In single-update mode, `cfg_half`, `cfg_dead` and `cfg_duty` are copied only at the clock edge that begins a period. Changes made between period starts have no effect on the outputs until then.
- R3: With `cfg_dbl`=1, the configuration is also copied at the upper turn: the edge where the rising counter reaches `HALF-1` loads the new `HALF` as the next count.
- R4: Phase p takes its duty from `cfg_duty[16p+15:16p]`, a signed value D. The raw high state is `count < D`. If D >= HALF the raw state is constant 1, and if D <= -HALF it is constant 0, so no transitions occur in either case. The raw state is registered once before the output stage.
- R5: The high side turns on only after the registered raw state has been 1 for `cfg_dead` cycles. The low side turns on only after it has been 0 for `cfg_dead` cycles. The two sides of a phase are never both active.
- R6: With `cfg_pol`=1 an active output is driven 1. With `cfg_pol`=0 it is driven 0, and every inactive output takes the opposite level.
- R7: `cfg_gate` bit p enables the high side of phase p and bit 3+p enables its low side. A disabled output stays at its inactive level.
- R8: `trip_n`=0 drives all six outputs inactive immediately, without a clock edge. The trip is latched, so the outputs stay inactive after `trip_n` returns to 1.
- R9: A one-cycle `trip_clr` pulse requests release. The latch clears only at the next period start, and only if `trip_n` is 1 at that edge.
- R10: A rising edge on `sync_in` restarts the period at the next clock edge. The counter loads `-cfg_half`, counts up, and the configuration is copied.
- R11: During and after reset, before the first period starts, all outputs are inactive and `pwm_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | CNT_W-1 | Half-span HALF; period is 4*HALF cycles |
| cfg_dead | input | DT_W | Dead gap in cycles |
| cfg_duty | input | PHASES*CNT_W | Signed duty per phase, phase p at bits 16p+15:16p |
| cfg_dbl | input | 1 | 1 = reload also at the upper turn |
| cfg_pol | input | 1 | Active level of all outputs |
| cfg_gate | input | 2*PHASES | Output enables: high sides low bits, low sides above |
| sync_in | input | 1 | Rising edge restarts the period |
| trip_n | input | 1 | Asynchronous active-low trip |
| trip_clr | input | 1 | Request to release a latched trip |
| pwm_hi | output | PHASES | High-side outputs |
| pwm_lo | output | PHASES | Low-side outputs |
| pwm_count | output | CNT_W | Signed counter value |
| period_start | output | 1 | High in the first cycle of each period |

## Verification
Several properties are checked on every cycle by assertions:
- the counter stays inside the active half-span and restarts at the negated half-span after each wrap;
- the active registers change only on a reload;
- no side turns on while its partner was on in the previous cycle;
- both sides of a phase are never active together;
- a low trip input holds every pin inactive;
- the trip latch falls only on a period boundary.

The remaining behaviour can only be shown by the bench scenarios:
- the exact cycle where edges land for a given duty;
- flat outputs at the clamped duty extremes;
- when mid-period writes become visible in each update mode;
- the effect of polarity and the enable mask;
- the sequence of trip, latch and release;
- an immediate restart on sync.

// File: rtl/tri_pwm_pkg.sv
`timescale 1ns/1ps
package tri_pwm_pkg;
  typedef enum logic {CNT_DOWN = 1'b0, CNT_UP = 1'b1} cnt_dir_e;
endpackage

// File: rtl/tri_pwm_counter.sv
`timescale 1ns/1ps
module tri_pwm_counter
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-2:0]        cfg_half,
  input  logic [CNT_W-2:0]        half_act,
  input  logic                    cfg_dbl,
  input  logic                    sync_in,
  output logic signed [CNT_W-1:0] cnt,
  output logic                    wrap,
  output logic                    mid_load,
  output logic                    running,
  output logic                    period_start
);
  localparam int EW = CNT_W + 1;
  localparam logic signed [EW-1:0]    ONE_E = EW'(1);
  localparam logic signed [CNT_W-1:0] ONE_C = CNT_W'(1);

  cnt_dir_e                dir_q;
  logic                    sync_q;
  logic                    sync_evt;
  logic                    mid;
  logic signed [EW-1:0]    cnt_x, half_x, top_turn, bot_turn;
  logic signed [CNT_W-1:0] new_half_c, act_half_c, cnt_d;
  cnt_dir_e                dir_d;

  always_comb begin
    cnt_x      = {cnt[CNT_W-1], cnt};
    half_x     = {2'b00, half_act};
    top_turn   = half_x - ONE_E;
    bot_turn   = ONE_E - half_x;
    new_half_c = {1'b0, cfg_half};
    act_half_c = {1'b0, half_act};
    sync_evt   = sync_in & ~sync_q;
    wrap       = sync_evt | ((dir_q == CNT_DOWN) && (cnt_x <= bot_turn));
    mid        = ~wrap & (dir_q == CNT_UP) & (cnt_x >= top_turn);
    mid_load   = mid & cfg_dbl;
    period_start = (dir_q == CNT_UP) && (cnt == -act_half_c);
    if (wrap) begin
      cnt_d = -new_half_c;
      dir_d = CNT_UP;
    end else if (mid) begin
      cnt_d = cfg_dbl ? new_half_c : act_half_c;
      dir_d = CNT_DOWN;
    end else begin
      cnt_d = (dir_q == CNT_UP) ? cnt + ONE_C : cnt - ONE_C;
      dir_d = dir_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      dir_q   <= CNT_DOWN;
      sync_q  <= 1'b0;
      running <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      dir_q   <= dir_d;
      sync_q  <= sync_in;
      if (wrap) running <= 1'b1;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_x <= half_x) && (cnt_x >= -half_x));

  // R10
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == -$past(new_half_c)) && (dir_q == CNT_UP));
endmodule

// File: rtl/tri_pwm_shadow.sv
`timescale 1ns/1ps
module tri_pwm_shadow #(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int PHASES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [CNT_W-2:0]          cfg_half,
  input  logic [DT_W-1:0]           cfg_dead,
  input  logic [PHASES*CNT_W-1:0]   cfg_duty,
  output logic [CNT_W-2:0]          half_act,
  output logic [DT_W-1:0]           dead_act,
  output logic [PHASES*CNT_W-1:0]   duty_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_act <= '0;
      dead_act <= '0;
      duty_act <= '0;
    end else if (load) begin
      half_act <= cfg_half;
      dead_act <= cfg_dead;
      duty_act <= cfg_duty;
    end
  end

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({half_act, dead_act, duty_act}) |-> $past(load));
endmodule

// File: rtl/tri_pwm_deadband.sv
`timescale 1ns/1ps
module tri_pwm_deadband #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [CNT_W-1:0] cnt,
  input  logic signed [CNT_W-1:0] duty,
  input  logic [CNT_W-2:0]        half_act,
  input  logic [DT_W-1:0]         dead_act,
  output logic                    hi_on,
  output logic                    lo_on
);
  localparam int EW = CNT_W + 1;

  logic signed [EW-1:0] cnt_x, duty_x, half_x;
  logic                 raw;
  logic                 raw_q;
  logic [DT_W-1:0]      age_q;

  always_comb begin
    cnt_x  = {cnt[CNT_W-1], cnt};
    duty_x = {duty[CNT_W-1], duty};
    half_x = {2'b00, half_act};
    if (duty_x >= half_x)       raw = 1'b1;
    else if (duty_x <= -half_x) raw = 1'b0;
    else                        raw = cnt_x < duty_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      age_q <= '0;
    end else if (raw != raw_q) begin
      raw_q <= raw;
      age_q <= '0;
    end else if (age_q != '1) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign hi_on = raw_q  & (age_q >= dead_act);
  assign lo_on = ~raw_q & (age_q >= dead_act);

  // R5
  gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_act != '0) && $rose(hi_on) |-> $past(!lo_on));
  // R5
  gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_act != '0) && $rose(lo_on) |-> $past(!hi_on));
endmodule

// File: rtl/tri_pwm_outstage.sv
`timescale 1ns/1ps
module tri_pwm_outstage #(
  parameter int PHASES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trip_n,
  input  logic                trip_clr,
  input  logic                wrap,
  input  logic                running,
  input  logic                pol,
  input  logic [2*PHASES-1:0] gate,
  input  logic [PHASES-1:0]   hi_on,
  input  logic [PHASES-1:0]   lo_on,
  output logic [PHASES-1:0]   pin_hi,
  output logic [PHASES-1:0]   pin_lo
);
  logic              trip_q;
  logic              clr_q;
  logic              clear_now;
  logic              allow;
  logic [PHASES-1:0] act_hi, act_lo;

  assign clear_now = wrap & clr_q & trip_n;

  always_ff @(posedge clk or negedge rst_n or negedge trip_n) begin
    if (!rst_n)         trip_q <= 1'b0;
    else if (!trip_n)   trip_q <= 1'b1;
    else if (clear_now) trip_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         clr_q <= 1'b0;
    else if (clear_now) clr_q <= 1'b0;
    else if (trip_clr)  clr_q <= 1'b1;
  end

  always_comb begin
    allow  = running & ~trip_q & trip_n;
    act_hi = hi_on & gate[PHASES-1:0]        & {PHASES{allow}};
    act_lo = lo_on & gate[2*PHASES-1:PHASES] & {PHASES{allow}};
    pin_hi = pol ? act_hi : ~act_hi;
    pin_lo = pol ? act_lo : ~act_lo;
  end

  // R8
  trip_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |-> (pin_hi == {PHASES{~pol}}) && (pin_lo == {PHASES{~pol}}));

  // R9
  trip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_q) |-> $past(wrap));
endmodule

// File: rtl/tri_pwm_core.sv
`timescale 1ns/1ps
module tri_pwm_core #(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int PHASES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-2:0]        cfg_half,
  input  logic [DT_W-1:0]         cfg_dead,
  input  logic [PHASES*CNT_W-1:0] cfg_duty,
  input  logic                    cfg_dbl,
  input  logic                    cfg_pol,
  input  logic [2*PHASES-1:0]     cfg_gate,
  input  logic                    sync_in,
  input  logic                    trip_n,
  input  logic                    trip_clr,
  output logic [PHASES-1:0]       pwm_hi,
  output logic [PHASES-1:0]       pwm_lo,
  output logic [CNT_W-1:0]        pwm_count,
  output logic                    period_start
);
  logic signed [CNT_W-1:0] cnt;
  logic                    wrap, mid_load, running, load;
  logic [CNT_W-2:0]        half_act;
  logic [DT_W-1:0]         dead_act;
  logic [PHASES*CNT_W-1:0] duty_act;
  logic [PHASES-1:0]       hi_on, lo_on;

  assign load      = wrap | mid_load;
  assign pwm_count = cnt;

  tri_pwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .half_act(half_act),
    .cfg_dbl(cfg_dbl), .sync_in(sync_in), .cnt(cnt), .wrap(wrap),
    .mid_load(mid_load), .running(running), .period_start(period_start)
  );

  tri_pwm_shadow #(.CNT_W(CNT_W), .DT_W(DT_W), .PHASES(PHASES)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_half(cfg_half),
    .cfg_dead(cfg_dead), .cfg_duty(cfg_duty), .half_act(half_act),
    .dead_act(dead_act), .duty_act(duty_act)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    tri_pwm_deadband #(.CNT_W(CNT_W), .DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .cnt(cnt),
      .duty(duty_act[p*CNT_W +: CNT_W]), .half_act(half_act),
      .dead_act(dead_act), .hi_on(hi_on[p]), .lo_on(lo_on[p])
    );

    // R5
    pin_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((pwm_hi[p] == cfg_pol) && (pwm_lo[p] == cfg_pol)));
  end

  tri_pwm_outstage #(.PHASES(PHASES)) u_out (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .trip_clr(trip_clr),
    .wrap(wrap), .running(running), .pol(cfg_pol), .gate(cfg_gate),
    .hi_on(hi_on), .lo_on(lo_on), .pin_hi(pwm_hi), .pin_lo(pwm_lo)
  );
endmodule

// File: tb/tri_pwm_core_tb.sv
`timescale 1ns/1ps
module tri_pwm_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 3;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int AGE_MAX = (1 << DW) - 1;
  localparam int WD_CYCLES = 150000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [CW-2:0]   cfg_half = 15'd10;
  logic [DW-1:0]   cfg_dead = 8'd2;
  logic [P*CW-1:0] cfg_duty = '0;
  logic            cfg_dbl = 1'b0;
  logic            cfg_pol = 1'b1;
  logic [2*P-1:0]  cfg_gate = '1;
  logic            sync_in = 1'b0;
  logic            trip_n = 1'b1;
  logic            trip_clr = 1'b0;
  logic [P-1:0]    pwm_hi, pwm_lo;
  logic [CW-1:0]   pwm_count;
  logic            period_start;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  tri_pwm_core #(.CNT_W(CW), .DT_W(DW), .PHASES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_dead(cfg_dead),
    .cfg_duty(cfg_duty), .cfg_dbl(cfg_dbl), .cfg_pol(cfg_pol),
    .cfg_gate(cfg_gate), .sync_in(sync_in), .trip_n(trip_n),
    .trip_clr(trip_clr), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .pwm_count(pwm_count), .period_start(period_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model, built from the requirements ----------
  int m_cnt, m_half, m_dt;
  int m_duty [P];
  bit m_raw  [P];
  int m_age  [P];
  bit m_up, m_run, m_flag, m_clrq, m_sync_q;
  bit t_sync, t_wrap, t_mid, t_clear, t_r;
  int t_d;

  function automatic int duty_of(int p);
    return int'($signed(cfg_duty[p*CW +: CW]));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_half = 0; m_dt = 0; m_up = 0;
      m_run = 0; m_flag = 0; m_clrq = 0; m_sync_q = 0;
      for (int p = 0; p < P; p++) begin
        m_duty[p] = 0; m_raw[p] = 0; m_age[p] = 0;
      end
    end else begin
      t_sync = sync_in && !m_sync_q;
      t_wrap = t_sync || (!m_up && (m_cnt <= 1 - m_half));
      t_mid  = !t_wrap && m_up && (m_cnt >= m_half - 1);
      for (int p = 0; p < P; p++) begin
        t_d = m_duty[p];
        if (t_d >= m_half)       t_r = 1;
        else if (t_d <= -m_half) t_r = 0;
        else                     t_r = (m_cnt < t_d);
        if (t_r != m_raw[p]) begin
          m_raw[p] = t_r; m_age[p] = 0;
        end else if (m_age[p] < AGE_MAX) begin
          m_age[p] = m_age[p] + 1;
        end
      end
      if (t_wrap) begin
        m_cnt = -int'(cfg_half); m_up = 1;
      end else if (t_mid) begin
        m_cnt = cfg_dbl ? int'(cfg_half) : m_half; m_up = 0;
      end else begin
        m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
      end
      if (t_wrap || (t_mid && cfg_dbl)) begin
        m_half = int'(cfg_half);
        m_dt   = int'(cfg_dead);
        for (int p = 0; p < P; p++) m_duty[p] = duty_of(p);
      end
      if (t_wrap) m_run = 1;
      t_clear = t_wrap && m_clrq && trip_n;
      if (!trip_n)      m_flag = 1;
      else if (t_clear) m_flag = 0;
      if (t_clear)       m_clrq = 0;
      else if (trip_clr) m_clrq = 1;
      m_sync_q = sync_in;
    end
  end

  function automatic bit exp_pin(bit lo, int p);
    bit inner, act;
    inner = (lo ? !m_raw[p] : m_raw[p]) && (m_age[p] >= m_dt);
    act = inner && cfg_gate[lo ? P + p : p] && m_run && !m_flag && trip_n;
    return cfg_pol ? act : !act;
  endfunction

  // ---------------- checking helpers ---------------------------------------
  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    logic [P-1:0] eh, el;
    int overlap;
    overlap = 0;
    for (int p = 0; p < P; p++) begin
      eh[p] = exp_pin(1'b0, p);
      el[p] = exp_pin(1'b1, p);
      if (pwm_hi[p] == cfg_pol && pwm_lo[p] == cfg_pol) overlap++;
    end
    check({req, " hi"}, int'(pwm_hi), int'(eh));
    check({req, " lo"}, int'(pwm_lo), int'(el));
    check({req, " count"}, int'($signed(pwm_count)), m_cnt);
    check({req, " start"}, int'(period_start), int'(m_up && (m_cnt == -m_half)));
    check("R5 overlap", overlap, 0);
  endtask

  task automatic set_duty(int p, int d);
    cfg_duty[p*CW +: CW] = CW'(d);
  endtask

  function automatic int rnd_duty(int h);
    return int'($urandom_range(2*h + 6)) - h - 3;
  endfunction

  task automatic run_cycles(int n, string req, bit rd, bit rg, bit rt, bit rs, bit rh);
    repeat (n) begin
      @(negedge clk);
      compare(req);
      if (rd && ($urandom_range(7) == 0))
        set_duty(int'($urandom_range(P-1)), rnd_duty(int'(cfg_half)));
      if (rg && ($urandom_range(5) == 0)) cfg_gate = 6'($urandom_range(63));
      if (rt && ($urandom_range(15) == 0)) cfg_dead = 8'($urandom_range(7));
      if (rh && ($urandom_range(31) == 0)) cfg_half = 15'($urandom_range(24, 3));
      sync_in = rs ? ($urandom_range(40) == 0) : 1'b0;
    end
  endtask

  task automatic wait_start(string req);
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      compare(req);
      guard++;
    end while (!period_start && guard < 400);
  endtask

  // ---------------- watchdog -----------------------------------------------
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus -----------------------------------------------
  initial begin
    int gap, cnt_a, cnt_b, cnt_c, lo_b, trans, act_cnt, h;
    logic [P-1:0] prev_hi;
    void'($urandom(32'd4242));
    set_duty(0, 4); set_duty(1, -3); set_duty(2, 0);

    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 hi", int'(pwm_hi), 0);
    check("R11 lo", int'(pwm_lo), 0);
    check("R11 count", int'(pwm_count), 0);
    check("R11 start", int'(period_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11");

    // R1 / R2: plain single-update running, period length
    run_cycles(100, "R1", 0, 0, 0, 0, 0);
    wait_start("R2");
    gap = 0;
    do begin
      @(negedge clk); compare("R2"); gap++;
    end while (!period_start && gap < 200);
    check("R2 period length", gap, 4 * 10);
    // R2: mid-period duty writes stay hidden until next start
    run_cycles(15, "R2", 0, 0, 0, 0, 0);
    set_duty(0, -6);
    run_cycles(60, "R2", 0, 0, 0, 0, 0);

    // R4: random duties in single mode
    run_cycles(400, "R4", 1, 0, 0, 0, 0);

    // R4: clamped extremes give flat outputs
    set_duty(0, 10); set_duty(1, -10); set_duty(2, 32767);
    wait_start("R4"); wait_start("R4");
    cnt_a = 0; cnt_b = 0; cnt_c = 0; lo_b = 0; trans = 0; prev_hi = pwm_hi;
    repeat (40) begin
      @(negedge clk); compare("R4");
      cnt_a += int'(pwm_hi[0]); cnt_b += int'(pwm_hi[1]);
      cnt_c += int'(pwm_hi[2]); lo_b += int'(pwm_lo[1]);
      if (pwm_hi != prev_hi) trans++;
      prev_hi = pwm_hi;
    end
    check("R4 full on", cnt_a, 40);
    check("R4 full off hi", cnt_b, 0);
    check("R4 full off lo", lo_b, 40);
    check("R4 saturated on", cnt_c, 40);
    check("R4 no edges", trans, 0);

    // R3: double update with random duty and half changes
    cfg_dbl = 1'b1;
    run_cycles(500, "R3", 1, 0, 0, 0, 1);

    // R5: varied dead gap
    cfg_half = 15'd12;
    run_cycles(500, "R5", 1, 0, 1, 0, 0);

    // R6: inverted polarity
    cfg_pol = 1'b0;
    run_cycles(300, "R6", 1, 0, 1, 0, 0);
    cfg_pol = 1'b1;

    // R7: random enable masks
    run_cycles(300, "R7", 1, 1, 0, 0, 0);
    cfg_gate = '1;
    cfg_dbl = 1'b0;
    cfg_half = 15'd8;
    set_duty(0, 2); set_duty(1, -2); set_duty(2, 5);
    wait_start("R8"); wait_start("R8");

    // R8: asynchronous trip, then latched
    run_cycles(7, "R8", 0, 0, 0, 0, 0);
    #2 trip_n = 1'b0;
    #1;
    check("R8 async hi", int'(pwm_hi), 0);
    check("R8 async lo", int'(pwm_lo), 0);
    run_cycles(3, "R8", 0, 0, 0, 0, 0);
    trip_n = 1'b1;
    act_cnt = 0;
    repeat (70) begin
      @(negedge clk); compare("R8");
      act_cnt += $countones(pwm_hi) + $countones(pwm_lo);
    end
    check("R8 latched", act_cnt, 0);

    // R9: release only at a period start
    wait_start("R9");
    trip_clr = 1'b1;
    @(negedge clk); compare("R9");
    trip_clr = 1'b0;
    act_cnt = 0;
    gap = 0;
    do begin
      @(negedge clk);
      compare("R9");
      if (!period_start) act_cnt += $countones(pwm_hi) + $countones(pwm_lo);
      gap++;
    end while (!period_start && gap < 200);
    check("R9 held until start", act_cnt, 0);
    act_cnt = int'($countones(pwm_hi) + $countones(pwm_lo));
    repeat (31) begin
      @(negedge clk); compare("R9");
      act_cnt += $countones(pwm_hi) + $countones(pwm_lo);
    end
    check("R9 released", int'(act_cnt > 0), 1);

    // R10: sync restarts the period
    run_cycles(13, "R10", 0, 0, 0, 0, 0);
    h = int'(cfg_half);
    sync_in = 1'b1;
    @(negedge clk);
    compare("R10");
    check("R10 restart count", int'($signed(pwm_count)), -h);
    check("R10 restart flag", int'(period_start), 1);
    sync_in = 1'b0;
    run_cycles(400, "R10", 1, 0, 0, 1, 1);
    sync_in = 1'b0;
    run_cycles(20, "R10", 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule